// File: doc/BRIEF.md
# Tachometer-Monitored Fan Sequencer

This block runs a cooling fan from a periodic temperature sample and watches the fan's tachometer line for signs of a stalled rotor. A one-second tick from the always-on timebase causes a new temperature word to be latched. A one-cycle strobe then goes out so that the sensor front end can start its next conversion. In automatic mode the latched temperature sets the PWM duty through a clamped linear ramp between two threshold parameters. In manual mode a host-written duty value is used instead. The host may change the mode or the manual value at any moment.

The fan's health is judged from rising edges on the tach input. If two tick intervals in a row pass with no edge, the block raises a fault and drives the fan at full duty until a new edge arrives. The only reset is `rstN`, which belongs to the always-on domain. The system reset that restarts the host is not an input, so fan control keeps running while the rest of the chip is held in reset. Setting `fanEn` low parks the block: the output is quiet, the duty is zero and the fault is cleared.

Top module: `fan_sequencer`

## Requirements
- R1: After `rstN` is released, `dutyOut` is 0, `pwmOut` is 0, `tachFault` is 0 and `sampleStrobe` is 0.
- R2: A clock cycle with `secTick` high and `fanEn` high latches `tempIn` and sets `sampleStrobe` high for the single following cycle. `sampleStrobe` is low again one cycle later if `secTick` has dropped.
- R3: In automatic mode (`manualMode` = 0), the applied duty for latched temperature t is 0 when t <= 40. It is 255 when t >= 80. Between those limits it is floor((t - 40) * 255 / 40).
- R4: In manual mode (`manualMode` = 1), the applied duty is `manualDuty`.
- R5: The PWM period is 256 clock cycles. With applied duty D, `pwmOut` is high for D cycles of each period when D < 255, and high for all 256 cycles when D = 255. With D = 0 it is never high.
- R6: A new duty is taken only at the wrap of the 8-bit period counter. `dutyOut` shows the duty currently applied and holds steady between wraps.
- R7: `tachFault` rises on the second `secTick` with no rising edge on `tachIn` since the last edge. The edge is seen after a two-stage synchroniser. The next rising edge of `tachIn` clears `tachFault`.
- R8: While `tachFault` is high, the duty taken at each wrap is 255, whatever the mode and temperature.
- R9: While `fanEn` is low, `pwmOut` is 0, `dutyOut` is 0, `tachFault` is 0 and `secTick` produces no `sampleStrobe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on domain clock |
| rstN | input | 1 | Active-low always-on domain reset |
| fanEn | input | 1 | Fan control enable |
| secTick | input | 1 | One-cycle pulse, once per second |
| tempIn | input | 8 | Temperature word from the sensor |
| manualMode | input | 1 | 1 selects the host duty, 0 selects the temperature ramp |
| manualDuty | input | 8 | Host-written duty |
| tachIn | input | 1 | Asynchronous tachometer pulse line |
| pwmOut | output | 1 | Fan PWM drive |
| dutyOut | output | 8 | Duty applied in the current period |
| tachFault | output | 1 | Fan stall indication |
| sampleStrobe | output | 1 | Temperature sample request pulse |

## Verification
The situation that is hardest to reach from the ports is a duty change landing in the middle of a PWM period. The period counter is not visible, so the bench finds a wrap by waiting for `dutyOut` to take a known value. It then changes `manualDuty` at once and checks that the old value holds for most of a period before the new one appears. The stall fault takes some care as well. The bench runs the tach line from a background toggler and stops it, lets the synchroniser drain, and then issues exactly two ticks. It also drops `fanEn` while the fault is active, to confirm that the fault clears.

// File: rtl/fan_seq_pkg.sv
package fan_seq_pkg;

  // Strobes that the control half hands to the datapath each cycle.
  typedef struct packed {
    logic runEn;      // fan control active
    logic capture;    // latch the temperature word this cycle
    logic forceFull;  // stall fault: demand full duty
  } ctrl_strobe_t;

endpackage

// File: rtl/fan_seq_ctrl.sv
module fan_seq_ctrl
  import fan_seq_pkg::*;
#(
  parameter int MISS_LIMIT  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         fanEn,
  input  logic         secTick,
  input  logic         tachIn,
  output ctrl_strobe_t strobes,
  output logic         sampleStrobe,
  output logic         tachFault
);

  localparam int MISS_W   = $clog2(MISS_LIMIT + 1);
  localparam int CHAIN_W  = SYNC_STAGES + 1;

  logic [CHAIN_W-1:0] tachChain;
  logic               tachRise;
  logic [MISS_W-1:0]  missCnt;

  // Synchroniser plus one history stage for edge detection.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tachChain <= '0;
    else       tachChain <= {tachChain[CHAIN_W-2:0], tachIn};
  end

  assign tachRise = tachChain[CHAIN_W-2] & ~tachChain[CHAIN_W-1];

  // Tick-window miss counter and fault flag.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      missCnt      <= '0;
      tachFault    <= 1'b0;
      sampleStrobe <= 1'b0;
    end else if (!fanEn) begin
      missCnt      <= '0;
      tachFault    <= 1'b0;
      sampleStrobe <= 1'b0;
    end else begin
      sampleStrobe <= secTick;
      if (tachRise) begin
        missCnt   <= '0;
        tachFault <= 1'b0;
      end else if (secTick) begin
        if (missCnt >= MISS_W'(MISS_LIMIT - 1)) begin
          tachFault <= 1'b1;
        end else begin
          missCnt <= missCnt + MISS_W'(1);
        end
      end
    end
  end

  always_comb begin
    strobes.runEn     = fanEn;
    strobes.capture   = fanEn & secTick;
    strobes.forceFull = tachFault;
  end

endmodule

// File: rtl/fan_seq_datapath.sv
module fan_seq_datapath
  import fan_seq_pkg::*;
#(
  parameter int TEMP_W  = 8,
  parameter int CNT_W   = 8,
  parameter int TEMP_LO = 40,
  parameter int TEMP_HI = 80
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      strobes,
  input  logic [TEMP_W-1:0] tempIn,
  input  logic              manualMode,
  input  logic [CNT_W-1:0]  manualDuty,
  output logic              pwmOut,
  output logic [CNT_W-1:0]  dutyOut
);

  localparam int DUTY_MAX = (1 << CNT_W) - 1;
  localparam int SPAN     = TEMP_HI - TEMP_LO;
  localparam int PROD_W   = TEMP_W + CNT_W;

  logic [TEMP_W-1:0] tempReg;
  logic [CNT_W-1:0]  autoDuty;
  logic [CNT_W-1:0]  targetDuty;
  logic [CNT_W-1:0]  pwmCnt;
  logic [CNT_W-1:0]  activeDuty;
  logic [PROD_W-1:0] rampOffset;
  logic [PROD_W-1:0] rampProd;
  logic [PROD_W-1:0] rampQuot;

  // Temperature latch.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                tempReg <= '0;
    else if (strobes.capture) tempReg <= tempIn;
  end

  // Clamped linear ramp.
  always_comb begin
    rampOffset = PROD_W'(tempReg) - PROD_W'(TEMP_LO);
    rampProd   = rampOffset * PROD_W'(DUTY_MAX);
    rampQuot   = rampProd / PROD_W'(SPAN);
    if (tempReg <= TEMP_W'(TEMP_LO))      autoDuty = '0;
    else if (tempReg >= TEMP_W'(TEMP_HI)) autoDuty = CNT_W'(DUTY_MAX);
    else                                  autoDuty = rampQuot[CNT_W-1:0];
  end

  // Duty source selection, fault first.
  always_comb begin
    if (strobes.forceFull) targetDuty = CNT_W'(DUTY_MAX);
    else if (manualMode)   targetDuty = manualDuty;
    else                   targetDuty = autoDuty;
  end

  // Period counter; duty loads at the wrap only.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwmCnt     <= '0;
      activeDuty <= '0;
    end else if (!strobes.runEn) begin
      pwmCnt     <= '0;
      activeDuty <= '0;
    end else begin
      pwmCnt <= pwmCnt + CNT_W'(1);
      if (pwmCnt == CNT_W'(DUTY_MAX)) activeDuty <= targetDuty;
    end
  end

  assign pwmOut  = strobes.runEn &
                   ((activeDuty == CNT_W'(DUTY_MAX)) | (pwmCnt < activeDuty));
  assign dutyOut = activeDuty;

endmodule

// File: rtl/fan_sequencer.sv
module fan_sequencer
  import fan_seq_pkg::*;
#(
  parameter int TEMP_W      = 8,
  parameter int CNT_W       = 8,
  parameter int TEMP_LO     = 40,
  parameter int TEMP_HI     = 80,
  parameter int MISS_LIMIT  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fanEn,
  input  logic              secTick,
  input  logic [TEMP_W-1:0] tempIn,
  input  logic              manualMode,
  input  logic [CNT_W-1:0]  manualDuty,
  input  logic              tachIn,
  output logic              pwmOut,
  output logic [CNT_W-1:0]  dutyOut,
  output logic              tachFault,
  output logic              sampleStrobe
);

  ctrl_strobe_t strobes;

  fan_seq_ctrl #(
    .MISS_LIMIT (MISS_LIMIT),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .fanEn       (fanEn),
    .secTick     (secTick),
    .tachIn      (tachIn),
    .strobes     (strobes),
    .sampleStrobe(sampleStrobe),
    .tachFault   (tachFault)
  );

  fan_seq_datapath #(
    .TEMP_W (TEMP_W),
    .CNT_W  (CNT_W),
    .TEMP_LO(TEMP_LO),
    .TEMP_HI(TEMP_HI)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .tempIn    (tempIn),
    .manualMode(manualMode),
    .manualDuty(manualDuty),
    .pwmOut    (pwmOut),
    .dutyOut   (dutyOut)
  );

endmodule

// File: rtl/fan_sequencer_chk.sv
module fan_sequencer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             fanEn,
  input logic             secTick,
  input logic             sampleStrobe,
  input logic             tachFault,
  input logic             pwmOut,
  input logic [CNT_W-1:0] dutyOut,
  input logic [CNT_W-1:0] pwmCnt
);

  localparam logic [CNT_W-1:0] FULL = '1;

  a_r2_strobe_follows_tick: assert property (@(posedge clk) disable iff (!rstN)
    sampleStrobe |-> $past(secTick && fanEn));

  a_r5_zero_duty_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (dutyOut == '0) |-> !pwmOut);

  a_r6_duty_held_midperiod: assert property (@(posedge clk) disable iff (!rstN)
    (pwmCnt != '0) |-> $stable(dutyOut));

  a_r7_fault_rises_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tachFault) |-> $past(secTick));

  a_r8_fault_full_duty: assert property (@(posedge clk) disable iff (!rstN)
    (tachFault && $past(tachFault) && pwmCnt == '0) |-> dutyOut == FULL);

  a_r9_disabled_parked: assert property (@(posedge clk) disable iff (!rstN)
    !fanEn |=> (dutyOut == '0 && !tachFault && !sampleStrobe));

endmodule

bind fan_sequencer fan_sequencer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .fanEn       (fanEn),
  .secTick     (secTick),
  .sampleStrobe(sampleStrobe),
  .tachFault   (tachFault),
  .pwmOut      (pwmOut),
  .dutyOut     (dutyOut),
  .pwmCnt      (u_dp.pwmCnt)
);

// File: tb/fan_sequencer_bench.sv
module fan_sequencer_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       fanEn = 1'b1;
  logic       secTick = 1'b0;
  logic [7:0] tempIn = 8'd0;
  logic       manualMode = 1'b0;
  logic [7:0] manualDuty = 8'd0;
  logic       tachIn = 1'b0;
  logic       pwmOut;
  logic [7:0] dutyOut;
  logic       tachFault;
  logic       sampleStrobe;

  int  checks = 0;
  int  fails = 0;
  bit  tachRun = 1'b0;
  bit  finished = 1'b0;

  always #10 clk = ~clk;

  fan_sequencer u_fan_sequencer (
    .clk(clk), .rstN(rstN), .fanEn(fanEn), .secTick(secTick),
    .tempIn(tempIn), .manualMode(manualMode), .manualDuty(manualDuty),
    .tachIn(tachIn), .pwmOut(pwmOut), .dutyOut(dutyOut),
    .tachFault(tachFault), .sampleStrobe(sampleStrobe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int expAuto(input int t);
    if (t <= 40) return 0;
    if (t >= 80) return 255;
    return ((t - 40) * 255) / 40;
  endfunction

  function automatic int expHigh(input int d);
    return (d == 255) ? 256 : d;
  endfunction

  task automatic pulseTick();
    @(negedge clk) secTick = 1'b1;
    @(negedge clk) secTick = 1'b0;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic countHigh(output int n);
    n = 0;
    repeat (256) begin
      @(negedge clk);
      if (pwmOut) n++;
    end
  endtask

  // Background tach source.
  initial begin
    forever begin
      repeat (20) @(negedge clk);
      if (tachRun) tachIn = ~tachIn;
      else         tachIn = 1'b0;
    end
  end

  // Watchdog.
  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    waitCycles(5);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(dutyOut == 0,      "R1 duty",   dutyOut, 0);
    check(pwmOut == 0,       "R1 pwm",    pwmOut, 0);
    check(tachFault == 0,    "R1 fault",  tachFault, 0);
    check(sampleStrobe == 0, "R1 strobe", sampleStrobe, 0);

    tachRun = 1'b1;
    waitCycles(50);

    // R2 strobe timing
    tempIn = 8'd30;
    pulseTick();
    check(sampleStrobe == 1, "R2 strobe high", sampleStrobe, 1);
    @(negedge clk);
    check(sampleStrobe == 0, "R2 strobe low", sampleStrobe, 0);

    // R3 full temperature sweep in automatic mode, R5 on a subset
    for (int t = 0; t < 256; t++) begin
      tempIn = 8'(t);
      pulseTick();
      waitCycles(258);
      check(dutyOut == 8'(expAuto(t)), "R3 auto duty", dutyOut, expAuto(t));
      if ((t % 16) == 15 || t == 40 || t == 41 || t == 79 || t == 80) begin
        countHigh(n);
        check(n == expHigh(expAuto(t)), "R5 pwm high count", n, expHigh(expAuto(t)));
      end
    end

    // R4 manual mode with R5 width checks
    manualMode = 1'b1;
    foreach (manualDuty[i]) begin end
    for (int k = 0; k < 8; k++) begin
      int d;
      case (k)
        0: d = 0;   1: d = 1;   2: d = 2;   3: d = 127;
        4: d = 128; 5: d = 200; 6: d = 254; default: d = 255;
      endcase
      manualDuty = 8'(d);
      waitCycles(258);
      check(dutyOut == 8'(d), "R4 manual duty", dutyOut, d);
      countHigh(n);
      check(n == expHigh(d), "R5 pwm high count", n, expHigh(d));
    end

    // R6 duty held until the wrap
    begin
      int guard = 0;
      bit held = 1'b1;
      int seen = 0;
      manualDuty = 8'd60;
      while (dutyOut != 8'd60 && guard < 600) begin
        @(negedge clk);
        guard++;
      end
      check(dutyOut == 8'd60, "R6 reach start", dutyOut, 60);
      manualDuty = 8'd190;
      for (int c = 0; c < 250; c++) begin
        @(negedge clk);
        if (dutyOut != 8'd60) begin
          held = 1'b0;
          seen = dutyOut;
        end
      end
      check(held, "R6 held mid-period", seen, 60);
      waitCycles(10);
      check(dutyOut == 8'd190, "R6 new at wrap", dutyOut, 190);
    end

    // R7 / R8 stall fault in automatic mode with a cold reading
    manualMode = 1'b0;
    tempIn = 8'd10;
    pulseTick();
    waitCycles(258);
    check(dutyOut == 0, "R3 cold duty", dutyOut, 0);
    tachRun = 1'b0;
    waitCycles(60);
    pulseTick();
    waitCycles(5);
    check(tachFault == 0, "R7 one miss no fault", tachFault, 0);
    pulseTick();
    check(tachFault == 1, "R7 second miss fault", tachFault, 1);
    waitCycles(258);
    check(dutyOut == 8'd255, "R8 fault full duty", dutyOut, 255);
    countHigh(n);
    check(n == 256, "R8 fault pwm always high", n, 256);

    // R9 disable while faulted
    fanEn = 1'b0;
    waitCycles(2);
    check(tachFault == 0, "R9 fault cleared", tachFault, 0);
    check(dutyOut == 0,   "R9 duty zero", dutyOut, 0);
    pulseTick();
    check(sampleStrobe == 0, "R9 no strobe", sampleStrobe, 0);
    countHigh(n);
    check(n == 0, "R9 pwm quiet", n, 0);

    // R7 fault cleared by a tach edge
    fanEn = 1'b1;
    waitCycles(5);
    pulseTick();
    pulseTick();
    check(tachFault == 1, "R7 fault again", tachFault, 1);
    tachRun = 1'b1;
    waitCycles(30);
    check(tachFault == 0, "R7 edge clears", tachFault, 0);
    waitCycles(520);
    check(dutyOut == 0, "R8 duty returns after clear", dutyOut, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule